// File: doc/BRIEF.md
# Pipeline Redirect and Exception Flush Controller

This block steers instruction flow in an in-order pipeline that always fetches down the sequential path and assumes every branch falls through. When a branch resolves taken in its resolution stage, the controller cancels the younger instructions already fetched on the wrong path and redirects fetch to the branch target. When any stage reports an exception, the controller picks the oldest live faulting instruction. It cancels that instruction and everything younger and records its PC as the resume point. It then redirects fetch to a fixed handler vector, while the older instructions further down keep draining.

The block holds a small copy of each in-flight instruction's control: a valid bit, a register-write enable, a memory-write enable and the PC. It drives per-stage kill lines and exposes what leaves the final stage as a commit port. A cancelled instruction moves on as a bubble with all of its write enables cleared. Stage 0 is fetch, and a larger stage index means an older instruction.

Top module: `flushUnit`

## Requirements
- R1: After reset no instruction is in flight: commitValid is 0 and stays 0 until the first fetched instruction reaches the last stage, kill is all zero, pcSel is 0 and epc is 0.
- R2: With no branch and no exception, pcSel is 0 (sequential), nextPc equals fetchPc + INSN_BYTES, and each fetched instruction appears on the commit port exactly NUM_STAGES-1 cycles later, in fetch order.
- R3: A branch that resolves not taken (brValid=1, brTaken=0) kills nothing and leaves pcSel at 0 and nextPc sequential.
- R4: A taken branch in stage BR_STAGE asserts kill for stages 0 to BR_STAGE-1 only, sets pcSel to 1 and nextPc to brTarget. Exactly BR_STAGE empty commit slots then separate the branch from the target instruction.
- R5: An exception taken in stage s asserts kill for stages 0 to s. Instructions in deeper (older) stages are not killed and still commit.
- R6: On the edge after an exception is taken, epc loads the PC of the excepting instruction. In cycles without a taken exception, epc keeps its value.
- R7: When several live stages flag an exception in one cycle, the deepest (oldest) one is taken.
- R8: A taken exception sets pcSel to 2 and nextPc to the handler VECTOR, and this overrides a taken branch in the same cycle.
- R9: An exception flagged by a stage younger than a branch resolving taken in the same cycle is ignored: pcSel stays 1 and epc is unchanged.
- R10: A killed instruction reaches the commit port with commitValid, commitRegWe and commitMemWe all 0.
- R11: If an older instruction raises an exception after a younger one was already taken, that older exception is taken too and epc is overwritten with the older PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | An instruction is being fetched this cycle (stage 0) |
| fetchPc | input | PC_W | PC of the instruction in fetch |
| fetchRegWe | input | 1 | Register-write enable of the fetched instruction |
| fetchMemWe | input | 1 | Memory-write enable of the fetched instruction |
| stageExc | input | NUM_STAGES | Exception flag raised by the instruction in each stage, bit 0 = fetch |
| brValid | input | 1 | A branch resolves in stage BR_STAGE this cycle |
| brTaken | input | 1 | The resolving branch is taken |
| brTarget | input | PC_W | Target of the resolving branch |
| pcSel | output | 2 | Next-PC source: 0 sequential, 1 branch target, 2 handler vector |
| nextPc | output | PC_W | PC to fetch on the next cycle |
| kill | output | NUM_STAGES | Per-stage cancel, bit s turns the instruction in stage s into a no-op |
| epc | output | PC_W | Saved PC of the last taken exception |
| commitValid | output | 1 | A live instruction leaves the last stage |
| commitPc | output | PC_W | PC of the instruction in the last stage |
| commitRegWe | output | 1 | Effective register-write enable at commit |
| commitMemWe | output | 1 | Effective memory-write enable at commit |

## Verification
A wrong choice of kill boundary shows up in the same cycle on the kill lines. It then appears on the commit port NUM_STAGES-1 cycles after the affected fetch, either as a wrong-path PC that should have been a bubble or as a missing older instruction. A wrong oldest-stage pick or a stale saved PC becomes visible on epc one edge after the exception. A wrong redirect priority shows at once on pcSel and nextPc. The directed scenarios therefore sample the combinational outputs in the cycle of the event and follow the commit port for the few cycles needed to count bubbles and spot the first correct-path instruction.

// File: rtl/flushPkg.sv
package flushPkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_VECTOR = 2'd2
  } pcSel_e;

  // Strobes from control to datapath: kill stages below killBound.
  typedef struct packed {
    pcSel_e           sel;
    logic             saveEpc;
    logic [IDX_W-1:0] killBound;
    logic [IDX_W-1:0] excIdx;
  } flushStrobe_t;
endpackage

// File: rtl/flushControl.sv
module flushControl
  import flushPkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int BR_STAGE   = 2
) (
  input  logic [NUM_STAGES-1:0] stageValid,
  input  logic [NUM_STAGES-1:0] stageExc,
  input  logic                  brValid,
  input  logic                  brTaken,
  output flushStrobe_t          strobe
);
  logic                  brFire;
  logic [NUM_STAGES-1:0] excLive;
  logic                  excFound;
  logic [IDX_W-1:0]      excAt;

  always_comb begin
    brFire = brValid & brTaken & stageValid[BR_STAGE];
    // Faults on the wrong path behind a taken branch never count.
    for (int s = 0; s < NUM_STAGES; s++) begin
      excLive[s] = stageValid[s] & stageExc[s] & ~(brFire & (s < BR_STAGE));
    end
    excFound = 1'b0;
    excAt    = '0;
    // Ascending scan: the last hit is the deepest, i.e. oldest, stage.
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (excLive[s]) begin
        excFound = 1'b1;
        excAt    = IDX_W'(s);
      end
    end

    strobe = '0;
    if (excFound) begin
      strobe.sel       = SEL_VECTOR;
      strobe.saveEpc   = 1'b1;
      strobe.killBound = excAt + IDX_W'(1);
      strobe.excIdx    = excAt;
    end else if (brFire) begin
      strobe.sel       = SEL_BRANCH;
      strobe.killBound = IDX_W'(BR_STAGE);
    end else begin
      strobe.sel       = SEL_SEQ;
    end
  end
endmodule

// File: rtl/flushDatapath.sv
module flushDatapath
  import flushPkg::*;
#(
  parameter int          NUM_STAGES = 5,
  parameter int          PC_W       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] VECTOR     = 32'h0000_0180
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fetchValid,
  input  logic [PC_W-1:0]       fetchPc,
  input  logic                  fetchRegWe,
  input  logic                  fetchMemWe,
  input  logic [PC_W-1:0]       brTarget,
  input  flushStrobe_t          strobe,
  output logic [NUM_STAGES-1:0] stageValid,
  output logic [NUM_STAGES-1:0] kill,
  output logic [PC_W-1:0]       nextPc,
  output logic [PC_W-1:0]       epc,
  output logic                  commitValid,
  output logic [PC_W-1:0]       commitPc,
  output logic                  commitRegWe,
  output logic                  commitMemWe
);
  localparam int SEL_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
  localparam int LAST  = NUM_STAGES - 1;

  logic [NUM_STAGES-1:1] rValid, rRegWe, rMemWe;
  logic [PC_W-1:0]       rPc [NUM_STAGES-1:1];

  logic [NUM_STAGES-1:0] sValid, sRegWe, sMemWe;
  logic [PC_W-1:0]       sPc [NUM_STAGES];
  logic [SEL_W-1:0]      excSel;

  always_comb begin
    sValid = {rValid, fetchValid};
    sRegWe = {rRegWe, fetchRegWe};
    sMemWe = {rMemWe, fetchMemWe};
    sPc[0] = fetchPc;
    for (int s = 1; s < NUM_STAGES; s++) sPc[s] = rPc[s];
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_kill
    assign kill[g] = (IDX_W'(g) < strobe.killBound);
  end

  assign stageValid = sValid;
  assign excSel     = strobe.excIdx[SEL_W-1:0];

  // Stage registers: a killed instruction advances as an empty bubble.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rValid <= '0;
      rRegWe <= '0;
      rMemWe <= '0;
      for (int s = 1; s < NUM_STAGES; s++) rPc[s] <= '0;
    end else begin
      for (int s = 1; s < NUM_STAGES; s++) begin
        rValid[s] <= sValid[s-1] & ~kill[s-1];
        rRegWe[s] <= sRegWe[s-1] & ~kill[s-1];
        rMemWe[s] <= sMemWe[s-1] & ~kill[s-1];
        rPc[s]    <= kill[s-1] ? '0 : sPc[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               epc <= '0;
    else if (strobe.saveEpc) epc <= sPc[excSel];
  end

  always_comb begin
    case (strobe.sel)
      SEL_BRANCH: nextPc = brTarget;
      SEL_VECTOR: nextPc = VECTOR[PC_W-1:0];
      default:    nextPc = fetchPc + PC_W'(INSN_BYTES);
    endcase
  end

  assign commitValid = sValid[LAST] & ~kill[LAST];
  assign commitRegWe = sRegWe[LAST] & ~kill[LAST];
  assign commitMemWe = sMemWe[LAST] & ~kill[LAST];
  assign commitPc    = sPc[LAST];
endmodule

// File: rtl/flushUnit.sv
module flushUnit
  import flushPkg::*;
#(
  parameter int          NUM_STAGES = 5,
  parameter int          BR_STAGE   = 2,
  parameter int          PC_W       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] VECTOR     = 32'h0000_0180
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fetchValid,
  input  logic [PC_W-1:0]       fetchPc,
  input  logic                  fetchRegWe,
  input  logic                  fetchMemWe,
  input  logic [NUM_STAGES-1:0] stageExc,
  input  logic                  brValid,
  input  logic                  brTaken,
  input  logic [PC_W-1:0]       brTarget,
  output logic [1:0]            pcSel,
  output logic [PC_W-1:0]       nextPc,
  output logic [NUM_STAGES-1:0] kill,
  output logic [PC_W-1:0]       epc,
  output logic                  commitValid,
  output logic [PC_W-1:0]       commitPc,
  output logic                  commitRegWe,
  output logic                  commitMemWe
);
  flushStrobe_t          strobe;
  logic [NUM_STAGES-1:0] stageValid;

  flushControl #(.NUM_STAGES(NUM_STAGES), .BR_STAGE(BR_STAGE)) u_ctl (
    .stageValid(stageValid),
    .stageExc  (stageExc),
    .brValid   (brValid),
    .brTaken   (brTaken),
    .strobe    (strobe)
  );

  flushDatapath #(
    .NUM_STAGES(NUM_STAGES), .PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .VECTOR(VECTOR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .fetchPc    (fetchPc),
    .fetchRegWe (fetchRegWe),
    .fetchMemWe (fetchMemWe),
    .brTarget   (brTarget),
    .strobe     (strobe),
    .stageValid (stageValid),
    .kill       (kill),
    .nextPc     (nextPc),
    .epc        (epc),
    .commitValid(commitValid),
    .commitPc   (commitPc),
    .commitRegWe(commitRegWe),
    .commitMemWe(commitMemWe)
  );

  assign pcSel = strobe.sel;
endmodule

// File: rtl/flushUnit_checker.sv
module flushUnit_checker #(
  parameter int          NUM_STAGES = 5,
  parameter int          BR_STAGE   = 2,
  parameter int          PC_W       = 32,
  parameter logic [31:0] VECTOR     = 32'h0000_0180
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [1:0]            pcSel,
  input logic [PC_W-1:0]       nextPc,
  input logic [PC_W-1:0]       brTarget,
  input logic [NUM_STAGES-1:0] kill,
  input logic [PC_W-1:0]       epc,
  input logic                  commitValid,
  input logic                  commitRegWe,
  input logic                  commitMemWe
);
  p_pcsel_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    pcSel != 2'd3);

  p_branch_redirect_r4: assert property (@(posedge clk) disable iff (!rstN)
    pcSel == 2'd1 |-> (nextPc == brTarget) && kill[BR_STAGE-1] && !kill[BR_STAGE]);

  // R5: the killed set is always a contiguous run starting at fetch.
  p_kill_contiguous_r5: assert property (@(posedge clk) disable iff (!rstN)
    (kill & (kill + NUM_STAGES'(1))) == '0);

  p_epc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    pcSel != 2'd2 |=> $stable(epc));

  p_vector_r8: assert property (@(posedge clk) disable iff (!rstN)
    pcSel == 2'd2 |-> nextPc == VECTOR[PC_W-1:0]);

  p_killed_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    kill[NUM_STAGES-1] |-> !commitValid && !commitRegWe && !commitMemWe);
endmodule

bind flushUnit flushUnit_checker #(
  .NUM_STAGES(NUM_STAGES), .BR_STAGE(BR_STAGE), .PC_W(PC_W), .VECTOR(VECTOR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pcSel      (pcSel),
  .nextPc     (nextPc),
  .brTarget   (brTarget),
  .kill       (kill),
  .epc        (epc),
  .commitValid(commitValid),
  .commitRegWe(commitRegWe),
  .commitMemWe(commitMemWe)
);

// File: tb/flushUnit_bench.sv
module flushUnit_bench;
  localparam int          NS   = 5;
  localparam int          BR   = 2;
  localparam logic [31:0] VEC  = 32'h0000_0180;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] TGT  = 32'h0000_8000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fetchValid = 1'b0;
  logic [31:0]   fetchPc = '0;
  logic          fetchRegWe = 1'b0;
  logic          fetchMemWe = 1'b0;
  logic [NS-1:0] stageExc = '0;
  logic          brValid = 1'b0;
  logic          brTaken = 1'b0;
  logic [31:0]   brTarget = '0;
  logic [1:0]    pcSel;
  logic [31:0]   nextPc;
  logic [NS-1:0] kill;
  logic [31:0]   epc;
  logic          commitValid;
  logic [31:0]   commitPc;
  logic          commitRegWe;
  logic          commitMemWe;

  int tests = 0;
  int fails = 0;
  logic [31:0] lastNext = BASE;

  always #2 clk = ~clk;

  flushUnit #(.NUM_STAGES(NS), .BR_STAGE(BR), .VECTOR(VEC)) u_flushUnit (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchRegWe(fetchRegWe), .fetchMemWe(fetchMemWe), .stageExc(stageExc),
    .brValid(brValid), .brTaken(brTaken), .brTarget(brTarget),
    .pcSel(pcSel), .nextPc(nextPc), .kill(kill), .epc(epc),
    .commitValid(commitValid), .commitPc(commitPc),
    .commitRegWe(commitRegWe), .commitMemWe(commitMemWe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; fetchValid = 1'b0; stageExc = '0; brValid = 1'b0; brTaken = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    lastNext = BASE;
    #1;
  endtask

  // One pipeline cycle: fetch at the PC the block chose last cycle.
  task automatic apply(input logic [NS-1:0] exc, input logic bv, input logic bt,
                       input logic [31:0] tgt);
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = lastNext; fetchRegWe = 1'b1; fetchMemWe = 1'b1;
    stageExc = exc; brValid = bv; brTaken = bt; brTarget = tgt;
    #1;
    lastNext = nextPc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) apply('0, 1'b0, 1'b0, '0);
  endtask

  task automatic testResetAndSequential();
    doReset();
    chk("R1 commitValid", {31'd0, commitValid}, 32'd0);
    chk("R1 kill", {27'd0, kill}, 32'd0);
    chk("R1 pcSel", {30'd0, pcSel}, 32'd0);
    chk("R1 epc", epc, 32'd0);
    for (int c = 0; c < 8; c++) begin
      apply('0, 1'b0, 1'b0, '0);
      chk("R2 nextPc", nextPc, BASE + 32'(4 * c + 4));
      chk("R2 pcSel", {30'd0, pcSel}, 32'd0);
      if (c < NS - 1) chk("R1 empty commit", {31'd0, commitValid}, 32'd0);
      else begin
        chk("R2 commitValid", {31'd0, commitValid}, 32'd1);
        chk("R2 commitPc", commitPc, BASE + 32'(4 * (c - 4)));
      end
    end
  endtask

  task automatic testNotTaken();
    doReset();
    idle(5);
    apply('0, 1'b1, 1'b0, TGT);
    chk("R3 kill", {27'd0, kill}, 32'd0);
    chk("R3 pcSel", {30'd0, pcSel}, 32'd0);
    chk("R3 nextPc", nextPc, BASE + 32'd24);
    idle(4);
    chk("R3 commit after fallthrough", commitPc, BASE + 32'd20);
  endtask

  task automatic testTakenBranch();
    int bubbles = 0;
    doReset();
    idle(5);
    apply('0, 1'b1, 1'b1, TGT);
    chk("R4 kill", {27'd0, kill}, 32'h3);
    chk("R4 pcSel", {30'd0, pcSel}, 32'd1);
    chk("R4 nextPc", nextPc, TGT);
    idle(2);
    chk("R4 branch commits", commitPc, BASE + 32'd12);
    for (int c = 8; c < 10; c++) begin
      idle(1);
      if (!commitValid) bubbles++;
      chk("R10 bubble writes", {30'd0, commitRegWe, commitMemWe}, 32'd0);
    end
    idle(1);
    chk("R4 bubble count", 32'(bubbles), 32'(BR));
    chk("R4 target commits", {31'd0, commitValid}, 32'd1);
    chk("R4 target pc", commitPc, TGT);
  endtask

  task automatic testExcOverBranch();
    doReset();
    idle(6);
    apply(5'b01000, 1'b1, 1'b1, TGT);
    chk("R8 pcSel", {30'd0, pcSel}, 32'd2);
    chk("R8 nextPc", nextPc, VEC);
    chk("R5 kill", {27'd0, kill}, 32'hF);
    chk("R5 older commits", {31'd0, commitValid}, 32'd1);
    chk("R5 older pc", commitPc, BASE + 32'd8);
    idle(1);
    chk("R6 epc", epc, BASE + 32'd12);
    for (int c = 7; c < 11; c++) begin
      if (c > 7) idle(1);
      chk("R10 killed commit", {29'd0, commitValid, commitRegWe, commitMemWe}, 32'd0);
    end
    idle(1);
    chk("R8 handler commits", commitPc, VEC);
    chk("R6 epc held", epc, BASE + 32'd12);
  endtask

  task automatic testOldestWins();
    doReset();
    idle(6);
    apply(5'b01010, 1'b0, 1'b0, '0);
    chk("R7 kill", {27'd0, kill}, 32'hF);
    idle(1);
    chk("R7 epc oldest", epc, BASE + 32'd12);
  endtask

  task automatic testOlderLater();
    doReset();
    idle(6);
    apply(5'b00100, 1'b0, 1'b0, '0);
    chk("R11 first kill", {27'd0, kill}, 32'h7);
    apply(5'b10000, 1'b0, 1'b0, '0);
    chk("R11 first epc", epc, BASE + 32'd16);
    chk("R11 second kill", {27'd0, kill}, 32'h1F);
    chk("R11 no commit", {31'd0, commitValid}, 32'd0);
    idle(1);
    chk("R11 epc overwritten", epc, BASE + 32'd12);
  endtask

  task automatic testWrongPathExc();
    doReset();
    idle(6);
    apply(5'b00010, 1'b1, 1'b1, TGT);
    chk("R9 pcSel", {30'd0, pcSel}, 32'd1);
    chk("R9 nextPc", nextPc, TGT);
    chk("R9 kill", {27'd0, kill}, 32'h3);
    idle(1);
    chk("R9 epc unchanged", epc, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    testResetAndSequential();
    testNotTaken();
    testTakenBranch();
    testExcOverBranch();
    testOldestWins();
    testOlderLater();
    testWrongPathExc();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule